// File: doc/BRIEF.md
# Quaternary Digit Adder with Binary Core

This block adds two quaternary digits and a binary carry-in, and produces both a binary result and the drive pattern for a four-level output stage. Each operand arrives as three threshold flags taken from comparators with rising thresholds, so a digit is a thermometer code rather than a binary number. Each operand is first turned into a 2-bit binary value. A 2-bit ripple adder built from two full adders then forms the sum and the carry-out. Last, the sum is turned into the six control lines that pick one conduction path in a single-supply level generator.

The block is purely combinational and has no clock or reset. A one-hot level word is also given as an output, so a checker can read the chosen level without decoding the control lines. An input whose flags do not form a legal thermometer pattern raises an error and forces a neutral result.

Top module: `qdig_add_top`

## Requirements
- R1: An operand's flags `{lo, mid, hi}` (bit 2 = lo, bit 0 = hi) are legal only as 3'b111 (level 0), 3'b011 (level 1), 3'b001 (level 2) and 3'b000 (level 3). A legal operand decodes to the binary value of its level.
- R2: When both operands are legal, `sum` equals (A + B + carry_in) mod 4, where A and B are the decoded levels.
- R3: When both operands are legal, `carry_out` is 1 exactly when A + B + carry_in is 4 or more. The carry is a single binary bit in both directions.
- R4: `ctl[5:0]` is 6'b101011 for sum 0, 6'b011010 for sum 1, 6'b011110 for sum 2 and 6'b101000 for sum 3.
- R5: `level[3:0]` is one-hot with bit k set when `sum` equals k, so exactly one output path is enabled for any result.
- R6: If either operand's flags are one of the four illegal patterns (3'b110, 3'b101, 3'b100, 3'b010), `bad_input` is 1, `sum` is 0, `carry_out` is 0, `ctl` is 6'b101011 and `level` is 4'b0001. Otherwise `bad_input` is 0.
- R7: The carry-in adds exactly one to the total. The extremes 0+0+0 (sum 0, no carry) and 3+3+1 (sum 3, carry 1) are produced correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_thr | input | 3 | Threshold flags of operand A, {lo, mid, hi} |
| b_thr | input | 3 | Threshold flags of operand B, {lo, mid, hi} |
| carry_in | input | 1 | Binary carry into the digit |
| ctl | output | 6 | Path-control lines for the level generator |
| sum | output | 2 | Binary value of the result digit |
| carry_out | output | 1 | Binary carry out of the digit |
| level | output | 4 | One-hot copy of the result level |
| bad_input | output | 1 | Set when either operand has an illegal flag pattern |

## Verification
The bench covers every flag pair with both carry values. Through this sweep it reaches every illegal pattern on each operand, including the case where the other operand is legal. A design that checked only one operand would let a wrong sum through, and a design that cleared only the sum would leave a stale carry or control word. The wrap points are checked on their own: 1+2+1 must carry with sum 0, and 3+3+1 must give sum 3 with a carry. An adder that dropped the carry between its two bits, or that ignored carry_in, would fail there. Each control word is compared bit for bit, because a control line swapped with its neighbour would enable two paths at once or none at all.

// File: rtl/qdig_pkg.sv
package qdig_pkg;
  localparam int DIGIT_W  = 2;
  localparam int NLEVELS  = 1 << DIGIT_W;
  localparam int THR_W    = NLEVELS - 1;
  localparam int CTL_W    = 6;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [THR_W-1:0]   thr_t;
  typedef logic [CTL_W-1:0]   ctl_t;
endpackage

// File: rtl/qdig_thr_decode.sv
module qdig_thr_decode
  import qdig_pkg::*;
(
  input  thr_t   thr,
  output digit_t val,
  output logic   illegal
);
  always_comb begin
    illegal = 1'b0;
    val     = '0;
    case (thr)
      3'b111:  val = 2'd0;
      3'b011:  val = 2'd1;
      3'b001:  val = 2'd2;
      3'b000:  val = 2'd3;
      default: illegal = 1'b1;
    endcase
  end

  // R1: a legal thermometer word decodes to the count of cleared flags
  always_comb begin
    if (!$isunknown(thr) && !illegal)
      a_r1_thermo_value: assert (32'(val) == THR_W - $countones(thr))
        else $error("decoded value does not match flag count");
  end
endmodule

// File: rtl/qdig_ripple_core.sv
module qdig_ripple_core
  import qdig_pkg::*;
(
  input  digit_t a,
  input  digit_t b,
  input  logic   ci,
  output digit_t s,
  output logic   co
);
  logic [DIGIT_W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < DIGIT_W; i++) begin : g_fa
    logic p;
    assign p      = a[i] ^ b[i];
    assign s[i]   = p ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (p & c[i]);
  end

  assign co = c[DIGIT_W];

  // R2, R3: the ripple chain matches arithmetic addition
  always_comb begin
    if (!$isunknown({a, b, ci}))
      a_r2_core_total: assert ({co, s} == ({1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, ci}))
        else $error("ripple total wrong");
  end
endmodule

// File: rtl/qdig_level_encode.sv
module qdig_level_encode
  import qdig_pkg::*;
(
  input  digit_t              code,
  output ctl_t                ctl,
  output logic [NLEVELS-1:0]  level
);
  logic x1, x0;
  assign x1 = code[1];
  assign x0 = code[0];

  // ctl bit order, MSB first: path select lines 0..5 of the driver
  assign ctl[5] = ~(x1 ^ x0);
  assign ctl[4] =   x1 ^ x0;
  assign ctl[3] = 1'b1;
  assign ctl[2] =   x1 & ~x0;
  assign ctl[1] = ~(x1 & x0);
  assign ctl[0] = ~(x1 | x0);

  for (genvar k = 0; k < NLEVELS; k++) begin : g_lvl
    assign level[k] = (code == digit_t'(k));
  end

  // R5: exactly one path enabled
  always_comb begin
    if (!$isunknown(code)) begin
      a_r5_one_path: assert ($onehot(level))
        else $error("level not one-hot");
      // R4: the lowest and the top control lines track the end levels
      a_r4_end_lines: assert ((ctl[0] == level[0]) && (ctl[1] == ~level[3]))
        else $error("control word disagrees with level");
    end
  end
endmodule

// File: rtl/qdig_add_top.sv
module qdig_add_top
  import qdig_pkg::*;
(
  input  logic [2:0] a_thr,
  input  logic [2:0] b_thr,
  input  logic       carry_in,
  output logic [5:0] ctl,
  output logic [1:0] sum,
  output logic       carry_out,
  output logic [3:0] level,
  output logic       bad_input
);
  thr_t   thr_in [2];
  digit_t val    [2];
  logic   ill    [2];

  assign thr_in[0] = a_thr;
  assign thr_in[1] = b_thr;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    qdig_thr_decode u_dec (
      .thr     (thr_in[g]),
      .val     (val[g]),
      .illegal (ill[g])
    );
  end

  digit_t raw_s;
  logic   raw_co;

  qdig_ripple_core u_core (
    .a  (val[0]),
    .b  (val[1]),
    .ci (carry_in),
    .s  (raw_s),
    .co (raw_co)
  );

  assign bad_input = ill[0] | ill[1];
  assign sum       = bad_input ? '0   : raw_s;
  assign carry_out = bad_input ? 1'b0 : raw_co;

  qdig_level_encode u_enc (
    .code  (sum),
    .ctl   (ctl),
    .level (level)
  );

  always_comb begin
    if (!$isunknown({a_thr, b_thr, carry_in})) begin
      // R6: rejected input leaves the neutral result
      a_r6_reject_zero: assert (!bad_input || (sum == 2'd0 && !carry_out && level == 4'b0001))
        else $error("illegal input not neutralised");
      // R5: the one-hot level tracks the binary sum
      a_r5_level_sum: assert (level[sum])
        else $error("level does not match sum");
    end
  end
endmodule

// File: tb/sim_qdig_add_top.sv
`timescale 1ns/1ps
module sim_qdig_add_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [2:0] a_thr, b_thr;
  logic       carry_in;
  logic [5:0] ctl;
  logic [1:0] sum;
  logic       carry_out;
  logic [3:0] level;
  logic       bad_input;

  int n_chk = 0;
  int n_bad = 0;

  qdig_add_top u0 (
    .a_thr(a_thr), .b_thr(b_thr), .carry_in(carry_in),
    .ctl(ctl), .sum(sum), .carry_out(carry_out),
    .level(level), .bad_input(bad_input)
  );

  // R1 flag meaning; returns -1 for an illegal pattern
  function automatic int lvl_of(input logic [2:0] f);
    case (f)
      3'b111: return 0;
      3'b011: return 1;
      3'b001: return 2;
      3'b000: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [5:0] ctl_of(input int s);
    case (s)
      0: return 6'b101011;
      1: return 6'b011010;
      2: return 6'b011110;
      default: return 6'b101000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%b b=%b ci=%b actual=%0h expected=%0h", req, a_thr, b_thr, carry_in, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] a, input logic [2:0] b, input logic ci);
    int la, lb, tot;
    logic ill;
    @(negedge clk);
    a_thr = a; b_thr = b; carry_in = ci;
    #1;
    la = lvl_of(a); lb = lvl_of(b);
    ill = (la < 0) || (lb < 0);
    chk("R6 bad_input", 32'(bad_input), 32'(ill));
    if (ill) begin
      chk("R6 sum",   32'(sum), 0);
      chk("R6 carry", 32'(carry_out), 0);
      chk("R6 ctl",   32'(ctl), 32'(6'b101011));
      chk("R6 level", 32'(level), 32'(4'b0001));
    end else begin
      tot = la + lb + int'(ci);
      chk("R2 sum",   32'(sum), 32'(tot % 4));
      chk("R3 carry", 32'(carry_out), 32'(tot >= 4));
      chk("R4 ctl",   32'(ctl), 32'(ctl_of(tot % 4)));
      chk("R5 level", 32'(level), 32'(4'b0001 << (tot % 4)));
    end
  endtask

  initial begin
    #50000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    a_thr = 3'b111; b_thr = 3'b111; carry_in = 1'b0;
    // R7 extremes and R1 decode
    apply(3'b111, 3'b111, 1'b0);
    apply(3'b000, 3'b000, 1'b1);
    apply(3'b011, 3'b001, 1'b1);   // R3 wrap: 1+2+1
    apply(3'b000, 3'b111, 1'b1);   // R7 carry-in alone makes the carry
    apply(3'b110, 3'b000, 1'b1);   // R6 illegal A, legal B
    apply(3'b000, 3'b010, 1'b1);   // R6 illegal B
    // exhaustive sweep, R1..R6
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 2; c++)
          apply(3'(a), 3'(b), 1'(c));
    // random mix biased to legal patterns
    for (int i = 0; i < 300; i++) begin
      logic [2:0] ra, rb;
      ra = ($urandom % 4 == 0) ? 3'($urandom) : (3'b111 >> ($urandom % 4));
      rb = ($urandom % 4 == 0) ? 3'($urandom) : (3'b111 >> ($urandom % 4));
      apply(ra, rb, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule